// File: doc/BRIEF.md
# Short-Operand Multiply Dispatcher

This block sits in an execute unit and dispatches 64-bit multiply operations to one of two engines. The first engine is an optional combinational 16x16 signed multiplier. The second is a pipelined 64x64 multiplier with a fixed latency. A range detector looks at both operands. When both fit in a signed 16-bit value and the operation asks for the low 64 bits of the product, the short engine answers in the same cycle that the operation is presented. Every other operation goes to the pipelined engine, and the block reports busy until that engine delivers.

The control is a two-state machine. In `IDLE`, a valid operation is either finished on the spot by the short engine or launched into the pipelined engine; the launch takes the transition `IDLE -> SLOW_RUN`. In `SLOW_RUN`, the block waits for the pipelined engine to signal done. The done cycle carries the result and takes the transition `SLOW_RUN -> IDLE`. A build parameter switches the short engine in or out. It is out by default, and results are the same either way.

Top module: `mul_dispatch`

## Requirements
- R1: After reset, `busy` and `out_valid` are both 0.
- R2: An operand qualifies as short when its bits 63 down to 15 are all equal, which is the range -32768 to 32767. The values 32767 and -32768 qualify. The values 32768 and -32769 do not.
- R3: With `FAST_EN`=1, an accepted operation with op code 0 (low product) and two qualifying operands raises `out_valid` in the same cycle as `in_valid`, and `busy` stays 0.
- R4: The short-path result is the 32-bit signed product sign-extended to 64 bits, which equals the low 64 bits of the full product.
- R5: An operation that does not qualify is accepted in `IDLE`. `busy` is 1 in the 1st through 4th cycles after acceptance. `out_valid` is 1 only in the 4th, and `busy` is 0 in the 5th.
- R6: Op code 1 returns bits 127:64 of the signed 128-bit product. Op codes 2 and 3 return bits 127:64 of the unsigned product. These codes always take the slow path, even with short operands.
- R7: `in_valid` while `busy` is 1 is ignored: exactly one `out_valid` pulse appears, and it carries the in-flight result.
- R8: With `FAST_EN`=0, every operation takes the slow path timing of R5, and its results equal those with `FAST_EN`=1.
- R9: In the first cycle with `busy` 0 after a slow result, a new operation is accepted, including a same-cycle short-path one.
- R10: Each accepted operation produces exactly one `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 low product, 1 signed high, 2/3 unsigned high |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| busy | output | 1 | Slow operation in flight; inputs ignored |
| out_valid | output | 1 | Result valid this cycle |
| result | output | 64 | Product result |

## Verification
A state register stuck in `SLOW_RUN` shows as `busy` staying high beyond the 4th cycle and as a missing acceptance in the very next operation. A machine that falls back to `IDLE` early shows as `busy` dropping before `out_valid`, or as a second pulse. A wrong range decision shows within the same cycle: `out_valid` appears where the slow latency was due, or fails to appear where it was not. Comparing against a second instance built without the short engine exposes any result mismatch on the first operation that uses the short engine.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        MOP_LO    = 2'd0,
        MOP_HI_S  = 2'd1,
        MOP_HI_U  = 2'd2,
        MOP_HI_U2 = 2'd3
    } mul_op_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_SLOW_RUN = 1'b1
    } disp_state_e;
endpackage

// File: rtl/mul_range_detect.sv
module mul_range_detect #(
    parameter int XLEN    = 64,
    parameter int SHORT_W = 16
) (
    input  logic [XLEN-1:0] val,
    output logic            fits
);
    localparam int TOP_W = XLEN - SHORT_W + 1;
    logic [TOP_W-1:0] upper;
    always_comb begin
        upper = val[XLEN-1:SHORT_W-1];
        fits  = (&upper) | ~(|upper);
    end
endmodule

// File: rtl/mul_short_fast.sv
module mul_short_fast #(
    parameter int XLEN    = 64,
    parameter int SHORT_W = 16
) (
    input  logic [SHORT_W-1:0] a_lo,
    input  logic [SHORT_W-1:0] b_lo,
    output logic [XLEN-1:0]    prod
);
    localparam int PW = 2 * SHORT_W;
    logic signed [SHORT_W-1:0] sa, sb;
    logic signed [PW-1:0]      p;
    always_comb begin
        sa   = a_lo;
        sb   = b_lo;
        p    = sa * sb;
        prod = {{(XLEN-PW){p[PW-1]}}, p};
    end
endmodule

// File: rtl/mul_slow_pipe.sv
module mul_slow_pipe
    import mul_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int LAT  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            done,
    output logic [XLEN-1:0] res
);
    localparam int FW = 2 * XLEN;

    logic signed [XLEN:0]   ea, eb;
    logic signed [FW-1:0]   full;
    logic [XLEN-1:0]        sel;
    logic                   use_unsigned;

    always_comb begin
        use_unsigned = (op == MOP_HI_U) || (op == MOP_HI_U2);
        ea   = {use_unsigned ? 1'b0 : a[XLEN-1], a};
        eb   = {use_unsigned ? 1'b0 : b[XLEN-1], b};
        full = ea * eb;
        sel  = (op == MOP_LO) ? full[XLEN-1:0] : full[FW-1:XLEN];
    end

    logic [LAT-1:0]  stg_v;
    logic [XLEN-1:0] stg_r [LAT];

    generate
        for (genvar i = 0; i < LAT; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_v[0] <= 1'b0;
                    else        stg_v[0] <= launch;
                    if (launch) stg_r[0] <= sel;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_v[i] <= 1'b0;
                    else        stg_v[i] <= stg_v[i-1];
                    stg_r[i] <= stg_r[i-1];
                end
            end
        end
    endgenerate

    assign done = stg_v[LAT-1];
    assign res  = stg_r[LAT-1];

    AST_PIPE_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $countones(stg_v) == 0); // R7
    AST_PIPE_LAUNCH_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> stg_v[0]); // R5
endmodule

// File: rtl/mul_dispatch.sv
module mul_dispatch
    import mul_pkg::*;
#(
    parameter int  XLEN     = 64,
    parameter int  SHORT_W  = 16,
    parameter int  SLOW_LAT = 4,
    parameter bit  FAST_EN  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [63:0]     opnd_a,
    input  logic [63:0]     opnd_b,
    output logic            busy,
    output logic            out_valid,
    output logic [63:0]     result
);
    localparam int CW = $clog2(SLOW_LAT + 2);

    disp_state_e     state_q, state_d;
    logic            use_fast, launch;
    logic [63:0]     fast_res, slow_res;
    logic            slow_done;

    // Short-engine selection
    generate
        if (FAST_EN) begin : g_fast
            logic a_fits, b_fits;
            mul_range_detect #(.XLEN(XLEN), .SHORT_W(SHORT_W)) u_rng_a (
                .val(opnd_a), .fits(a_fits));
            mul_range_detect #(.XLEN(XLEN), .SHORT_W(SHORT_W)) u_rng_b (
                .val(opnd_b), .fits(b_fits));
            mul_short_fast #(.XLEN(XLEN), .SHORT_W(SHORT_W)) u_fast (
                .a_lo(opnd_a[SHORT_W-1:0]), .b_lo(opnd_b[SHORT_W-1:0]),
                .prod(fast_res));
            assign use_fast = a_fits && b_fits && (op == MOP_LO);
        end else begin : g_nofast
            assign use_fast = 1'b0;
            assign fast_res = '0;
        end
    endgenerate

    assign launch = (state_q == ST_IDLE) && in_valid && !use_fast;

    mul_slow_pipe #(.XLEN(XLEN), .LAT(SLOW_LAT)) u_slow (
        .clk(clk), .rst_n(rst_n), .launch(launch), .op(op),
        .a(opnd_a), .b(opnd_b), .done(slow_done), .res(slow_res));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch)    state_d = ST_SLOW_RUN;
            ST_SLOW_RUN: if (slow_done) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        out_valid = 1'b0;
        result    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && use_fast) begin
                    out_valid = 1'b1;
                    result    = fast_res;
                end
            end
            ST_SLOW_RUN: begin
                busy = 1'b1;
                if (slow_done) begin
                    out_valid = 1'b1;
                    result    = slow_res;
                end
            end
            default: ;
        endcase
    end

    // Busy-window counter for checking only
    logic [CW-1:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !busy && !out_valid); // R1
    AST_SLOW_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && !out_valid) |=> busy); // R5
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < CW'(SLOW_LAT)); // R5
    AST_SLOW_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == CW'(SLOW_LAT - 1)) |-> out_valid); // R5
    AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt < CW'(SLOW_LAT - 1)) |-> !out_valid); // R10
    AST_HIGH_NEVER_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid && op != MOP_LO) |-> !out_valid); // R6
    AST_OFF_ALL_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!FAST_EN && out_valid) |-> busy); // R8
    AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({launch, slow_done && !busy})); // R10
endmodule

// File: tb/mul_dispatch_tb.sv
module mul_dispatch_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        busy_f, ov_f, busy_r, ov_r;
    logic [63:0] res_f, res_r;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mul_dispatch #(.SLOW_LAT(LAT), .FAST_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy_f), .out_valid(ov_f), .result(res_f));

    mul_dispatch #(.SLOW_LAT(LAT), .FAST_EN(1'b0)) dut_ref (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy_r), .out_valid(ov_r), .result(res_r));

    function automatic logic [63:0] model(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
        logic [127:0] sa, sb, ua, ub, ps, pu;
        sa = {{64{a[63]}}, a};
        sb = {{64{b[63]}}, b};
        ua = {64'd0, a};
        ub = {64'd0, b};
        ps = sa * sb;
        pu = ua * ub;
        case (o)
            2'd0:    return pu[63:0];
            2'd1:    return ps[127:64];
            default: return pu[127:64];
        endcase
    endfunction

    task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation; in_valid held 'hold' extra cycles with other operands.
    task automatic run_op(input string req, input logic [1:0] o, input logic [63:0] a,
                          input logic [63:0] b, input bit exp_fast, input int hold);
        logic [63:0] exp, rf, rr;
        int lat_f, lat_r, cnt_f, cnt_r;
        bit busy_ok;
        lat_f = -1; lat_r = -1; cnt_f = 0; cnt_r = 0; busy_ok = 1'b1;
        rf = '0; rr = '0;
        exp = model(o, a, b);
        @(posedge clk); #1;
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b;
        for (int k = 0; k < 10; k++) begin
            if (k > 0) begin
                @(posedge clk); #1;
                if (k > hold) in_valid = 1'b0;
                else begin opnd_a = ~a; opnd_b = b + 64'd77; op = 2'd1; end
            end
            #1;
            if (ov_f) begin cnt_f++; if (lat_f < 0) begin lat_f = k; rf = res_f; end end
            if (ov_r) begin cnt_r++; if (lat_r < 0) begin lat_r = k; rr = res_r; end end
            if (busy_f !== ((!exp_fast && k >= 1 && k <= LAT) ? 1'b1 : 1'b0)) busy_ok = 1'b0;
        end
        chk({req, " latency"}, lat_f == (exp_fast ? 0 : LAT), 64'(lat_f), exp_fast ? 64'd0 : 64'(LAT));
        chk({req, " result"}, rf === exp, rf, exp);
        chk({req, " busy window"}, busy_ok, 64'(busy_f), 64'(!exp_fast));
        chk({req, " R10 single pulse"}, cnt_f == 1, 64'(cnt_f), 64'd1);
        chk({req, " R8 ref latency"}, lat_r == LAT, 64'(lat_r), 64'(LAT));
        chk({req, " R8 ref result"}, rr === exp, rr, exp);
    endtask

    // R9: slow op, then a short op in the first idle cycle
    task automatic back_to_back();
        logic [63:0] e1, e2;
        bit seen1;
        e1 = model(2'd0, 64'd100000, 64'd3);
        e2 = model(2'd0, 64'd12, -64'd5);
        seen1 = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b1; op = 2'd0; opnd_a = 64'd100000; opnd_b = 64'd3;
        for (int k = 1; k <= LAT + 1; k++) begin
            @(posedge clk); #1;
            if (k == 1) in_valid = 1'b0;
            if (k == LAT + 1) begin in_valid = 1'b1; opnd_a = 64'd12; opnd_b = -64'd5; end
            #1;
            if (k == LAT && ov_f && res_f === e1) seen1 = 1'b1;
            if (k == LAT + 1) begin
                chk("R9 first result", seen1, 64'(seen1), 64'd1);
                chk("R9 idle after slow", busy_f === 1'b0, 64'(busy_f), 64'd0);
                chk("R9 fast accepted", ov_f === 1'b1, 64'(ov_f), 64'd1);
                chk("R9 fast value", res_f === e2, res_f, e2);
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (LAT + 3) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk("R1 busy", busy_f === 1'b0, 64'(busy_f), 64'd0);
        chk("R1 out_valid", ov_f === 1'b0, 64'(ov_f), 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk("R1 busy after release", busy_f === 1'b0 && busy_r === 1'b0, 64'(busy_f), 64'd0);

        run_op("R3 R4 small positive", 2'd0, 64'd123, 64'd456, 1'b1, 0);
        run_op("R4 small mixed sign", 2'd0, -64'd300, 64'd77, 1'b1, 0);
        run_op("R2 upper bound", 2'd0, 64'd32767, 64'd32767, 1'b1, 0);
        run_op("R2 lower bound", 2'd0, -64'd32768, -64'd32768, 1'b1, 0);
        run_op("R2 R5 just above", 2'd0, 64'd32768, 64'd2, 1'b0, 0);
        run_op("R2 R5 just below", 2'd0, 64'd5, -64'd32769, 1'b0, 0);
        run_op("R5 large operands", 2'd0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1'b0, 0);
        run_op("R6 signed high small", 2'd1, -64'd7, 64'd9, 1'b0, 0);
        run_op("R6 signed high large", 2'd1, 64'h8000_0000_0000_0001, 64'h7fff_ffff_0000_0003, 1'b0, 0);
        run_op("R6 unsigned high", 2'd2, 64'hffff_ffff_ffff_fff0, 64'hffff_0000_ffff_0000, 1'b0, 0);
        run_op("R6 code three", 2'd3, -64'd2, -64'd3, 1'b0, 0);
        run_op("R7 held while busy", 2'd0, 64'd70000, -64'd70000, 1'b0, LAT);
        back_to_back();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule